// File: doc/BRIEF.md
# Subroutine Call and Return Sequencer

This block owns the program counter of a small processor core. That core fetches instructions either from a local register RAM of 512 words or from a larger, byte-addressed shared hub memory. The decode stage presents one operation per cycle on a strobe, together with a 17-bit target. The sequencer works out the next program counter and the return address, and it places that return address in one of three locations. The first is a four-entry hardware return stack. The second is a fixed link word in register RAM. The third is one of two stacks in hub memory, each addressed through its own pointer.

Internal-stack calls and link calls finish in a single cycle. Hub-stack calls and returns issue one request on a request/acknowledge hub port. The program counter is frozen until that request is acknowledged, and new operations are refused during the wait. A target below word 512 is treated as register-RAM code, which advances one word per instruction. Any other target is treated as hub code, which advances four bytes per instruction.

Top module: `callret_seq`

## Requirements
- R1: After reset, pc is 0, the return-stack depth is 0, busy, hub_req, rw_en, stk_ovf and stk_unf are 0, ptra reads 0x08000 and ptrb reads 0x0C000.
- R2: op_kind 0 (step) moves pc to the next instruction: pc+1 when pc < 0x200, otherwise pc+4. The change is visible one cycle after the strobe.
- R3: op_kind 1 (call) pushes the next-instruction address onto the internal stack and loads pc with op_target. op_kind 2 (return) loads pc with the most recent entry still on the stack. Entries come back in last-in, first-out order.
- R4: A call while four entries are held drops the oldest entry, keeps the depth at 4, and raises stk_ovf for exactly one cycle.
- R5: A return on an empty internal stack loads pc with 0 and raises stk_unf for exactly one cycle.
- R6: op_kind 3 (link) loads pc with op_target. One cycle after the strobe it pulses rw_en for one cycle, with rw_addr 0x1EF and rw_data equal to the next-instruction address. The internal stack is left untouched.
- R7: op_kind 4 and 5 (hub call through ptra and ptrb respectively) issue a hub write at the selected pointer minus 4, carrying the next-instruction address. On acknowledge, the pointer becomes that address and pc becomes op_target.
- R8: op_kind 6 and 7 (hub return through ptra and ptrb respectively) issue a hub read at the selected pointer. On acknowledge, pc becomes hub_rdata and the pointer advances by 4.
- R9: While a hub request waits for hub_ack, busy is 1 and pc, hub_addr and hub_we are held. A strobe arriving in that time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Decoded operation strobe |
| op_kind | input | 3 | Operation code (0 step, 1 call, 2 return, 3 link, 4/5 hub call A/B, 6/7 hub return A/B) |
| op_target | input | 17 | Call destination |
| pc | output | 17 | Current program counter |
| busy | output | 1 | Hub stack operation in flight |
| stk_depth | output | 3 | Entries held in the internal return stack |
| stk_ovf | output | 1 | One-cycle pulse: push onto a full stack |
| stk_unf | output | 1 | One-cycle pulse: pop from an empty stack |
| rw_en | output | 1 | Register-RAM write enable for the link word |
| rw_addr | output | 9 | Register-RAM write address |
| rw_data | output | 17 | Register-RAM write data (return address) |
| hub_req | output | 1 | Hub request |
| hub_we | output | 1 | Hub request is a write |
| hub_addr | output | 17 | Hub byte address |
| hub_wdata | output | 17 | Hub write data |
| hub_rdata | input | 17 | Hub read data, valid with hub_ack |
| hub_ack | input | 1 | Hub acknowledge |
| ptra | output | 17 | First hub stack pointer |
| ptrb | output | 17 | Second hub stack pointer |

## Verification
The bench fills the internal stack past its depth and then drains it until it underflows. A stack that kept the newest entry instead of dropping the oldest would return the wrong address on the fourth return, and a stack that left stale data in place would not return zero on the fifth. It steps the pc across the 0x1FF/0x200 boundary and makes calls from both regions, which catches a return-address increment that uses the wrong step size on either side of the boundary. For hub calls and returns it holds off the acknowledge for several cycles and strobes a step during the wait. A design that did not freeze the pc, or that accepted the step, would show a moved pc or a changed request. Pre-decrement on push and post-increment on pop are checked at hub_addr and at the pointers, so an off-by-four pointer update is visible.

// File: rtl/callret_pkg.sv
// Package: operation codes and the hub-stack command shared by the
// sequencer and its hub-stack unit. Assumes a 3-bit decoded op field.
package callret_pkg;

    typedef enum logic [2:0] {
        OP_STEP  = 3'd0,
        OP_CALL  = 3'd1,
        OP_RET   = 3'd2,
        OP_LINK  = 3'd3,
        OP_CALLA = 3'd4,
        OP_CALLB = 3'd5,
        OP_RETA  = 3'd6,
        OP_RETB  = 3'd7
    } op_e;

    typedef struct packed {
        logic push;   // 1: call (write), 0: return (read)
        logic sel_b;  // 1: second pointer, 0: first pointer
    } hub_cmd_t;

endpackage

// File: rtl/crs_lifo.sv
// Return-address stack held as a shift register, entry 0 being the top.
// A push shifts everything down, so a full stack loses its oldest entry.
// A pop shifts everything up and fills the bottom with zero.
// Assumes push and pop are never requested in the same cycle.
module crs_lifo #(
    parameter int W     = 17,
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  top,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [W-1:0]  slot [DEPTH];
    logic [CW-1:0] cnt_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i == 0) begin : g_head
            // Top entry: takes new data on push, the entry below on pop
            always_ff @(posedge clk) begin
                if (!rst_n)    slot[i] <= '0;
                else if (push) slot[i] <= din;
                else if (pop)  slot[i] <= (DEPTH > 1) ? slot[(DEPTH > 1) ? 1 : 0] : '0;
            end
        end else if (i == DEPTH - 1) begin : g_tail
            // Bottom entry: takes the one above on push, zero on pop
            always_ff @(posedge clk) begin
                if (!rst_n)    slot[i] <= '0;
                else if (push) slot[i] <= slot[i-1];
                else if (pop)  slot[i] <= '0;
            end
        end else begin : g_mid
            // Middle entry: shifts down on push, up on pop
            always_ff @(posedge clk) begin
                if (!rst_n)    slot[i] <= '0;
                else if (push) slot[i] <= slot[i-1];
                else if (pop)  slot[i] <= slot[i+1];
            end
        end
    end

    // Occupancy counter, saturating at both ends
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (push && cnt_q != DEPTH_C)  cnt_q <= cnt_q + CW'(1);
        else if (pop && cnt_q != '0)        cnt_q <= cnt_q - CW'(1);
    end

    assign count = cnt_q;
    assign full  = (cnt_q == DEPTH_C);
    assign empty = (cnt_q == '0);
    assign top   = empty ? '0 : slot[0];

endmodule

// File: rtl/crs_hubstk.sv
// Hub-memory stack unit: holds two stack pointers and runs one request
// at a time on the hub port. A push writes at pointer-STEP and stores that
// address as the new pointer. A pop reads at the pointer and then adds
// STEP to it. Assumes start is raised only while idle, and that the hub
// port acknowledges in the same cycle it returns read data.
module crs_hubstk
    import callret_pkg::*;
#(
    parameter int             AW        = 17,
    parameter int             STEP      = 4,
    parameter logic [AW-1:0]  PTRA_INIT = '0,
    parameter logic [AW-1:0]  PTRB_INIT = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  hub_cmd_t      cmd,
    input  logic [AW-1:0] wdata,
    input  logic          hub_ack,
    output logic          busy,
    output logic          done,
    output logic          hub_req,
    output logic          hub_we,
    output logic [AW-1:0] hub_addr,
    output logic [AW-1:0] hub_wdata,
    output logic [AW-1:0] ptr_a,
    output logic [AW-1:0] ptr_b
);

    localparam logic [AW-1:0] STEP_C = AW'(STEP);

    logic          busy_q;
    hub_cmd_t      cmd_q;
    logic [AW-1:0] wdata_q;
    logic [AW-1:0] cur_ptr;

    assign done = busy_q && hub_ack;

    for (genvar g = 0; g < 2; g++) begin : g_ptr
        logic [AW-1:0] p_q;
        // Stack pointer g: moves only when its own transfer completes
        always_ff @(posedge clk) begin
            if (!rst_n)
                p_q <= (g == 0) ? PTRA_INIT : PTRB_INIT;
            else if (done && (cmd_q.sel_b == 1'(g)))
                p_q <= cmd_q.push ? p_q - STEP_C : p_q + STEP_C;
        end
    end

    assign ptr_a = g_ptr[0].p_q;
    assign ptr_b = g_ptr[1].p_q;

    // Transfer state: captures the command at start, clears on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            cmd_q   <= '0;
            wdata_q <= '0;
        end else if (start) begin
            busy_q  <= 1'b1;
            cmd_q   <= cmd;
            wdata_q <= wdata;
        end else if (done) begin
            busy_q  <= 1'b0;
        end
    end

    // Request address from the selected pointer
    always_comb begin
        cur_ptr  = cmd_q.sel_b ? ptr_b : ptr_a;
        hub_addr = cmd_q.push ? cur_ptr - STEP_C : cur_ptr;
    end

    assign busy      = busy_q;
    assign hub_req   = busy_q;
    assign hub_we    = busy_q && cmd_q.push;
    assign hub_wdata = wdata_q;

endmodule

// File: rtl/callret_seq.sv
// Call/return sequencer: owns the program counter and routes return
// addresses to an internal stack, a fixed link word in register RAM, or one
// of two hub-memory stacks. Assumes the decode stage holds at most one
// strobe per cycle and treats strobes seen while busy as dropped.
module callret_seq
    import callret_pkg::*;
#(
    parameter int                PC_W        = 17,
    parameter int                RS_DEPTH    = 4,
    parameter int                LOCAL_WORDS = 512,
    parameter int                LINK_REG    = 'h1EF,
    parameter int                HUB_STEP    = 4,
    parameter logic [PC_W-1:0]   RESET_PC    = '0,
    parameter logic [PC_W-1:0]   PTRA_INIT   = 17'h08000,
    parameter logic [PC_W-1:0]   PTRB_INIT   = 17'h0C000,
    localparam int               DEPTH_W     = $clog2(RS_DEPTH + 1),
    localparam int               RA_W        = $clog2(LOCAL_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [2:0]         op_kind,
    input  logic [PC_W-1:0]    op_target,
    output logic [PC_W-1:0]    pc,
    output logic               busy,
    output logic [DEPTH_W-1:0] stk_depth,
    output logic               stk_ovf,
    output logic               stk_unf,
    output logic               rw_en,
    output logic [RA_W-1:0]    rw_addr,
    output logic [PC_W-1:0]    rw_data,
    output logic               hub_req,
    output logic               hub_we,
    output logic [PC_W-1:0]    hub_addr,
    output logic [PC_W-1:0]    hub_wdata,
    input  logic [PC_W-1:0]    hub_rdata,
    input  logic               hub_ack,
    output logic [PC_W-1:0]    ptra,
    output logic [PC_W-1:0]    ptrb
);

    localparam logic [PC_W-1:0] LOCAL_LIM = PC_W'(LOCAL_WORDS);
    localparam logic [PC_W-1:0] WORD_INC  = PC_W'(1);
    localparam logic [PC_W-1:0] BYTE_INC  = PC_W'(HUB_STEP);
    localparam logic [RA_W-1:0] LINK_ADDR = RA_W'(LINK_REG);

    op_e                kind;
    hub_cmd_t           cmd;
    logic               accept, is_hub_op;
    logic               lifo_push, lifo_pop, lifo_full, lifo_empty;
    logic [PC_W-1:0]    lifo_top;
    logic               hub_busy, hub_done, hub_start;
    logic [PC_W-1:0]    pc_q, tgt_q, ret_addr;
    logic               hub_push_q;
    logic               ovf_q, unf_q, rw_en_q;
    logic [PC_W-1:0]    rw_data_q;

    // Decode of the strobe into stack actions
    always_comb begin
        kind       = op_e'(op_kind);
        accept     = op_valid && !hub_busy;
        is_hub_op  = kind inside {OP_CALLA, OP_CALLB, OP_RETA, OP_RETB};
        cmd.push   = kind inside {OP_CALLA, OP_CALLB};
        cmd.sel_b  = kind inside {OP_CALLB, OP_RETB};
        lifo_push  = accept && (kind == OP_CALL);
        lifo_pop   = accept && (kind == OP_RET);
        hub_start  = accept && is_hub_op;
    end

    // Address of the instruction after the current one
    assign ret_addr = pc_q + ((pc_q < LOCAL_LIM) ? WORD_INC : BYTE_INC);

    crs_lifo #(
        .W     (PC_W),
        .DEPTH (RS_DEPTH),
        .CW    (DEPTH_W)
    ) u_lifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (lifo_push),
        .pop   (lifo_pop),
        .din   (ret_addr),
        .top   (lifo_top),
        .count (stk_depth),
        .full  (lifo_full),
        .empty (lifo_empty)
    );

    crs_hubstk #(
        .AW        (PC_W),
        .STEP      (HUB_STEP),
        .PTRA_INIT (PTRA_INIT),
        .PTRB_INIT (PTRB_INIT)
    ) u_hub (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (hub_start),
        .cmd       (cmd),
        .wdata     (ret_addr),
        .hub_ack   (hub_ack),
        .busy      (hub_busy),
        .done      (hub_done),
        .hub_req   (hub_req),
        .hub_we    (hub_we),
        .hub_addr  (hub_addr),
        .hub_wdata (hub_wdata),
        .ptr_a     (ptra),
        .ptr_b     (ptrb)
    );

    // Program counter: hub completion, or a newly accepted operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q       <= RESET_PC;
            tgt_q      <= '0;
            hub_push_q <= 1'b0;
        end else if (hub_done) begin
            pc_q <= hub_push_q ? tgt_q : hub_rdata;
        end else if (accept) begin
            case (kind)
                OP_STEP:          pc_q <= ret_addr;
                OP_CALL, OP_LINK: pc_q <= op_target;
                OP_RET:           pc_q <= lifo_top;
                default: begin
                    tgt_q      <= op_target;
                    hub_push_q <= cmd.push;
                end
            endcase
        end
    end

    // One-cycle stack fault pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            ovf_q <= lifo_push && lifo_full;
            unf_q <= lifo_pop && lifo_empty;
        end
    end

    // Link-word write toward register RAM
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rw_en_q   <= 1'b0;
            rw_data_q <= '0;
        end else begin
            rw_en_q <= accept && (kind == OP_LINK);
            if (accept && (kind == OP_LINK)) rw_data_q <= ret_addr;
        end
    end

    assign pc      = pc_q;
    assign busy    = hub_busy;
    assign stk_ovf = ovf_q;
    assign stk_unf = unf_q;
    assign rw_en   = rw_en_q;
    assign rw_addr = LINK_ADDR;
    assign rw_data = rw_data_q;

endmodule

// File: rtl/callret_seq_chk.sv
// Checker for the call/return sequencer: port-level temporal properties.
// Assumes it is bound to callret_seq with the same parameter values.
module callret_seq_chk #(
    parameter int PC_W        = 17,
    parameter int RS_DEPTH    = 4,
    parameter int LOCAL_WORDS = 512,
    parameter int HUB_STEP    = 4,
    parameter int DEPTH_W     = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PC_W-1:0]    pc,
    input logic               busy,
    input logic [DEPTH_W-1:0] stk_depth,
    input logic               stk_ovf,
    input logic               stk_unf,
    input logic               rw_en,
    input logic [PC_W-1:0]    rw_data,
    input logic               hub_req,
    input logic               hub_we,
    input logic [PC_W-1:0]    hub_addr,
    input logic               hub_ack,
    input logic [PC_W-1:0]    ptra,
    input logic [PC_W-1:0]    ptrb
);

    function automatic logic [PC_W-1:0] nxt(input logic [PC_W-1:0] p);
        return p + ((p < PC_W'(LOCAL_WORDS)) ? PC_W'(1) : PC_W'(HUB_STEP));
    endfunction

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        stk_depth <= DEPTH_W'(RS_DEPTH));                                  // R4
    AST_OVF_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        stk_ovf |-> (stk_depth == DEPTH_W'(RS_DEPTH)));                    // R4
    AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        stk_ovf |=> (!stk_ovf || stk_depth == DEPTH_W'(RS_DEPTH)));        // R4
    AST_UNF_ZERO_PC: assert property (@(posedge clk) disable iff (!rst_n)
        stk_unf |-> (pc == '0 && stk_depth == '0));                        // R5
    AST_LINK_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        rw_en |-> (rw_data == nxt($past(pc))));                            // R6
    AST_PUSH_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (hub_req && hub_ack && hub_we) |=>
            (ptra == $past(hub_addr) || ptrb == $past(hub_addr)));         // R7
    AST_POP_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (hub_req && hub_ack && !hub_we) |=>
            (ptra == $past(hub_addr) + PC_W'(HUB_STEP) ||
             ptrb == $past(hub_addr) + PC_W'(HUB_STEP)));                  // R8
    AST_STALL_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !hub_ack) |=> $stable(pc));                               // R9
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hub_req && !hub_ack) |=>
            (hub_req && $stable(hub_addr) && $stable(hub_we)));            // R9

endmodule

bind callret_seq callret_seq_chk #(
    .PC_W        (PC_W),
    .RS_DEPTH    (RS_DEPTH),
    .LOCAL_WORDS (LOCAL_WORDS),
    .HUB_STEP    (HUB_STEP),
    .DEPTH_W     (DEPTH_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc        (pc),
    .busy      (busy),
    .stk_depth (stk_depth),
    .stk_ovf   (stk_ovf),
    .stk_unf   (stk_unf),
    .rw_en     (rw_en),
    .rw_data   (rw_data),
    .hub_req   (hub_req),
    .hub_we    (hub_we),
    .hub_addr  (hub_addr),
    .hub_ack   (hub_ack),
    .ptra      (ptra),
    .ptrb      (ptrb)
);

// File: tb/callret_seq_tb.sv
// Scoreboard bench: driver tasks compute expected port values from the
// requirements and queue them with the cycle they are due; a monitor pops
// and compares them at the falling edge.
module callret_seq_tb;

    localparam int W = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [2:0]    op_kind = '0;
    logic [W-1:0]  op_target = '0;
    logic [W-1:0]  pc, rw_data, hub_addr, hub_wdata, ptra, ptrb;
    logic [W-1:0]  hub_rdata = '0;
    logic          hub_ack = 1'b0;
    logic          busy, stk_ovf, stk_unf, rw_en, hub_req, hub_we;
    logic [2:0]    stk_depth;
    logic [8:0]    rw_addr;

    callret_seq u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_target(op_target), .pc(pc), .busy(busy), .stk_depth(stk_depth),
        .stk_ovf(stk_ovf), .stk_unf(stk_unf), .rw_en(rw_en), .rw_addr(rw_addr),
        .rw_data(rw_data), .hub_req(hub_req), .hub_we(hub_we),
        .hub_addr(hub_addr), .hub_wdata(hub_wdata), .hub_rdata(hub_rdata),
        .hub_ack(hub_ack), .ptra(ptra), .ptrb(ptrb)
    );

    always #2.5 clk = ~clk;

    typedef enum int {S_PC, S_DEPTH, S_OVF, S_UNF, S_RWEN, S_RWADDR, S_RWDATA,
                      S_REQ, S_WE, S_HADDR, S_HWDATA, S_BUSY, S_PTRA, S_PTRB} sig_e;
    typedef struct {
        int           due;
        sig_e         sig;
        logic [W-1:0] exp;
        string        req;
    } item_t;

    item_t        sbq[$];
    int           cyc = 0;
    int           n_chk = 0;
    int           n_err = 0;
    logic [W-1:0] m_pc;
    logic [W-1:0] m_stk[$];
    logic [W-1:0] m_pa = 17'h08000;
    logic [W-1:0] m_pb = 17'h0C000;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [W-1:0] actual(sig_e s);
        case (s)
            S_PC:     return pc;
            S_DEPTH:  return W'(stk_depth);
            S_OVF:    return W'(stk_ovf);
            S_UNF:    return W'(stk_unf);
            S_RWEN:   return W'(rw_en);
            S_RWADDR: return W'(rw_addr);
            S_RWDATA: return rw_data;
            S_REQ:    return W'(hub_req);
            S_WE:     return W'(hub_we);
            S_HADDR:  return hub_addr;
            S_HWDATA: return hub_wdata;
            S_BUSY:   return W'(busy);
            S_PTRA:   return ptra;
            default:  return ptrb;
        endcase
    endfunction

    // Monitor: compares every queued item that is due this cycle
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            item_t it;
            logic [W-1:0] a;
            it = sbq.pop_front();
            a = actual(it.sig);
            n_chk++;
            if (a !== it.exp) begin
                n_err++;
                $display("FAIL %s: %s actual 0x%0h expected 0x%0h",
                         it.req, it.sig.name(), a, it.exp);
            end
        end
    end

    function automatic logic [W-1:0] nxt(logic [W-1:0] p);
        return p + ((p < 17'h200) ? 17'd1 : 17'd4);
    endfunction

    task automatic expect_v(sig_e s, logic [W-1:0] v, string r);
        item_t it;
        it.due = cyc; it.sig = s; it.exp = v; it.req = r;
        sbq.push_back(it);
    endtask

    // Drive one strobe; returns just after the edge that captures it
    task automatic issue(int k, logic [W-1:0] tgt);
        op_valid = 1'b1; op_kind = 3'(k); op_target = tgt;
        @(posedge clk); #1;
        op_valid = 1'b0;
    endtask

    // Single-cycle operation (step, call, return, link) with model update
    task automatic local_op(int k, logic [W-1:0] tgt, string r);
        logic [W-1:0] ret;
        logic ovf, unf;
        ret = nxt(m_pc); ovf = 1'b0; unf = 1'b0;
        case (k)
            0: m_pc = ret;
            1: begin
                m_stk.push_front(ret);
                if (m_stk.size() > 4) begin void'(m_stk.pop_back()); ovf = 1'b1; end
                m_pc = tgt;
            end
            2: begin
                if (m_stk.size() == 0) begin m_pc = '0; unf = 1'b1; end
                else m_pc = m_stk.pop_front();
            end
            default: m_pc = tgt;
        endcase
        issue(k, tgt);
        expect_v(S_PC, m_pc, r);
        expect_v(S_DEPTH, W'(m_stk.size()), r);
        expect_v(S_OVF, W'(ovf), r);
        expect_v(S_UNF, W'(unf), r);
        expect_v(S_RWEN, W'(k == 3), r);
        expect_v(S_BUSY, '0, r);
        if (k == 3) begin
            expect_v(S_RWADDR, 17'h1EF, r);
            expect_v(S_RWDATA, ret, r);
        end
    endtask

    // Hub-stack operation: stall for some cycles with a stray strobe
    task automatic hub_op(int k, logic [W-1:0] tgt, int stall,
                          logic [W-1:0] rdata, string r);
        logic push, selb;
        logic [W-1:0] ret, ptr, addr, old_pc;
        push = (k == 4 || k == 5);
        selb = (k == 5 || k == 7);
        ret = nxt(m_pc);
        ptr = selb ? m_pb : m_pa;
        addr = push ? ptr - 17'd4 : ptr;
        old_pc = m_pc;
        issue(k, tgt);
        expect_v(S_REQ, 17'd1, r);
        expect_v(S_WE, W'(push), r);
        expect_v(S_HADDR, addr, r);
        if (push) expect_v(S_HWDATA, ret, r);
        expect_v(S_PC, old_pc, r);
        for (int i = 0; i < stall; i++) begin
            op_valid = 1'b1; op_kind = 3'd0; op_target = 17'h0;
            @(posedge clk); #1;
            op_valid = 1'b0;
            expect_v(S_PC, old_pc, "R9");
            expect_v(S_BUSY, 17'd1, "R9");
            expect_v(S_REQ, 17'd1, "R9");
            expect_v(S_HADDR, addr, "R9");
            expect_v(S_DEPTH, W'(m_stk.size()), "R9");
        end
        hub_ack = 1'b1; hub_rdata = rdata;
        @(posedge clk); #1;
        hub_ack = 1'b0; hub_rdata = '0;
        m_pc = push ? tgt : rdata;
        if (selb) m_pb = push ? addr : ptr + 17'd4;
        else      m_pa = push ? addr : ptr + 17'd4;
        expect_v(S_PC, m_pc, r);
        expect_v(S_BUSY, '0, r);
        expect_v(S_REQ, '0, r);
        expect_v(S_PTRA, m_pa, r);
        expect_v(S_PTRB, m_pb, r);
    endtask

    // Watchdog: an expired run counts as a failure and still reports
    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // Stimulus
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        m_pc = '0;
        // R1 reset state
        expect_v(S_PC, '0, "R1");
        expect_v(S_DEPTH, '0, "R1");
        expect_v(S_BUSY, '0, "R1");
        expect_v(S_REQ, '0, "R1");
        expect_v(S_RWEN, '0, "R1");
        expect_v(S_OVF, '0, "R1");
        expect_v(S_UNF, '0, "R1");
        expect_v(S_PTRA, 17'h08000, "R1");
        expect_v(S_PTRB, 17'h0C000, "R1");
        // R2 steps in register RAM
        local_op(0, '0, "R2");
        local_op(0, '0, "R2");
        local_op(0, '0, "R2");
        // R3 calls from both regions, then R4 overflow
        local_op(1, 17'h00040, "R3");
        local_op(1, 17'h01000, "R3");
        local_op(0, '0, "R2");
        local_op(1, 17'h00050, "R3");
        local_op(1, 17'h00060, "R3");
        local_op(1, 17'h00070, "R4");
        // R3 LIFO drain; oldest entry was dropped; R5 empty pop
        local_op(2, '0, "R3");
        local_op(2, '0, "R3");
        local_op(2, '0, "R3");
        local_op(2, '0, "R3");
        local_op(2, '0, "R5");
        local_op(0, '0, "R5");
        // R6 link, then R2 step across the region boundary
        local_op(3, 17'h001FF, "R6");
        local_op(0, '0, "R2");
        local_op(0, '0, "R2");
        // R7 / R8 hub stacks with stalls (R9)
        hub_op(4, 17'h02000, 3, '0, "R7");
        hub_op(5, 17'h00300, 2, '0, "R7");
        hub_op(7, '0, 2, 17'h02004, "R8");
        hub_op(6, '0, 1, 17'h00208, "R8");
        local_op(0, '0, "R2");
        repeat (3) @(posedge clk);
        if (sbq.size() != 0) begin
            n_err++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sbq.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule